// File: doc/BRIEF.md
# Cache Region Activity Vector Generator

This block watches the access stream of one cache and reduces it to an eight-bit map of busy regions. The cache's sets are split into eight contiguous groups, called super sets. Each group has its own saturating access counter. When the interval tick arrives, each counter is compared with the active threshold. The results are latched as the activity vector, and all counters restart from zero. The latched vector is held until the next tick. It serves the scheduler as the forecast of activity for the coming interval.

A data cache, an instruction cache and a unified second-level cache each get a separate instance, and each instance produces its own vector. Accesses come in on a valid/ready stream. The block always accepts: `acc_ready` is held high, so a producer never stalls and an access counts in every cycle where `acc_valid` is high. A threshold written by software goes into a pending slot and takes effect only at the next interval boundary. The tick, the threshold write and the access strobe are plain control pins.

Top module: `ss_activity_vec`

## Requirements
- R1: The super-set number of an access is the top three bits of `acc_set` (bits SET_W-1 down to SET_W-3). An accepted access increments only that super set's counter.
- R2: At a tick, vector bit i is 1 when counter i is strictly greater than the active threshold, and 0 when the counter is equal to it or smaller.
- R3: `vec_out` changes only on the clock edge that samples `tick` high. Between ticks it holds its value, whatever accesses arrive.
- R4: All counters restart on the tick edge. An access accepted in the tick cycle counts toward the new interval and not toward the vector being latched.
- R5: Counters saturate at 2^CNT_W-1 (255 by default) and never wrap around.
- R6: A threshold write sets the pending value. The pending value becomes active at the next tick edge, and the vector latched at that same edge still uses the previous active threshold. The active threshold after reset is THR_RST (2 by default).
- R7: After reset, `vec_valid` is 0 and `vec_out` is all zeros. `vec_valid` goes to 1 on the first tick and stays at 1.
- R8: `acc_ready` is always 1. A cycle with `acc_valid` low changes no counter, whatever `acc_set` holds.
- R9: The lower SET_W-3 bits of `acc_set` do not affect which counter is incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Cache access strobe |
| acc_ready | output | 1 | Always 1; the block never applies back-pressure |
| acc_set | input | SET_W | Set index of the access |
| tick | input | 1 | Interval boundary |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | CNT_W | New threshold value |
| vec_out | output | 8 | Latched activity vector, bit i for super set i |
| vec_valid | output | 1 | Set once the first interval has completed |

## Verification
Two kinds of same-cycle collision matter here. The first is an access arriving in the cycle of the tick, which could be lost or counted in the wrong interval. The bench drives an access with the tick. It then checks that this access is missing from the vector latched at that tick. It also checks that the access appears in the vector of the next interval, once the threshold is set so that a single access flips the bit. The second is a threshold write landing in the same cycle as the tick. The bench checks that this write is ignored by the vector latched at that boundary and is used only at the boundary after it.

// File: rtl/ss_pkg.sv
package ss_pkg;
  localparam int SS_W   = 3;
  localparam int NUM_SS = 1 << SS_W;
  typedef logic [NUM_SS-1:0] ss_vec_t;
endpackage

// File: rtl/ss_counter.sv
module ss_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= CNT_W'(hit);
    end else if (hit && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ss_thresh_reg.sv
module ss_thresh_reg #(
  parameter int CNT_W = 8,
  parameter int THR_RST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             boundary,
  output logic [CNT_W-1:0] thr_active
);
  logic [CNT_W-1:0] thr_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_pending <= CNT_W'(THR_RST);
      thr_active  <= CNT_W'(THR_RST);
    end else begin
      if (wr_en) thr_pending <= wr_data;
      if (boundary) thr_active <= thr_pending;
    end
  end
endmodule

// File: rtl/ss_vec_latch.sv
module ss_vec_latch
  import ss_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    capture,
  input  ss_vec_t bits_in,
  output ss_vec_t vec,
  output logic    valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec   <= '0;
      valid <= 1'b0;
    end else if (capture) begin
      vec   <= bits_in;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/ss_activity_vec.sv
module ss_activity_vec
  import ss_pkg::*;
#(
  parameter int SET_W   = 6,
  parameter int CNT_W   = 8,
  parameter int THR_RST = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic [SET_W-1:0]    acc_set,
  input  logic                tick,
  input  logic                thr_wr_en,
  input  logic [CNT_W-1:0]    thr_wr_data,
  output logic [NUM_SS-1:0]   vec_out,
  output logic                vec_valid
);
  localparam int SS_LSB = SET_W - SS_W;

  logic             acc_fire;
  logic [SS_W-1:0]  ss_idx;
  logic [CNT_W-1:0] thr_active;
  ss_vec_t          over;

  assign acc_ready = 1'b1;
  assign acc_fire  = acc_valid && acc_ready;
  assign ss_idx    = acc_set[SET_W-1:SS_LSB];

  ss_thresh_reg #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_en), .wr_data(thr_wr_data),
    .boundary(tick), .thr_active(thr_active)
  );

  for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
    logic             hit;
    logic [CNT_W-1:0] count;
    assign hit = acc_fire && (ss_idx == SS_W'(i));
    ss_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr(tick), .count(count)
    );
    assign over[i] = count > thr_active;
  end

  ss_vec_latch u_latch (
    .clk(clk), .rst_n(rst_n), .capture(tick), .bits_in(over),
    .vec(vec_out), .valid(vec_valid)
  );
endmodule

// File: rtl/ss_activity_vec_chk.sv
module ss_activity_vec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] vec_out,
  input logic         vec_valid
);
  assert_vec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(vec_out));
  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> vec_valid);
  assert_zero_until_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> vec_out == '0);
  assert_tick_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> vec_valid);
  assert_valid_from_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(tick));
endmodule

bind ss_activity_vec ss_activity_vec_chk #(.W(ss_pkg::NUM_SS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .vec_out(vec_out), .vec_valid(vec_valid)
);

// File: tb/ss_activity_vec_tb.sv
`timescale 1ns/1ps
module ss_activity_vec_tb;
  localparam int SET_W = 6;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_ready;
  logic [SET_W-1:0] acc_set = '0;
  logic tick = 1'b0;
  logic thr_wr_en = 1'b0;
  logic [CNT_W-1:0] thr_wr_data = '0;
  logic [7:0] vec_out;
  logic vec_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int cnt [8];
  int thr_act = 2;
  int thr_pend = 2;
  logic [7:0] exp_vec = '0;
  logic exp_valid = 1'b0;

  always #4 clk = ~clk;

  ss_activity_vec #(.SET_W(SET_W), .CNT_W(CNT_W), .THR_RST(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_set(acc_set), .tick(tick), .thr_wr_en(thr_wr_en),
    .thr_wr_data(thr_wr_data), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    check(req, {23'd0, vec_valid, vec_out}, {23'd0, exp_valid, exp_vec});
  endtask

  // One clock: inputs applied at negedge, model updated, returns at next negedge.
  task automatic step(bit v, logic [SET_W-1:0] s, bit t, bit we, int wd);
    @(negedge clk);
    acc_valid = v; acc_set = s; tick = t; thr_wr_en = we; thr_wr_data = CNT_W'(wd);
    if (t) begin
      for (int i = 0; i < 8; i++) exp_vec[i] = (cnt[i] > thr_act);
      exp_valid = 1'b1;
      thr_act = thr_pend;
      for (int i = 0; i < 8; i++) cnt[i] = 0;
    end
    if (v && cnt[s[SET_W-1 -: 3]] < CMAX) cnt[s[SET_W-1 -: 3]]++;
    if (we) thr_pend = wd;
    @(negedge clk);
    acc_valid = 1'b0; tick = 1'b0; thr_wr_en = 1'b0;
  endtask

  task automatic hits(int ss, int n);
    for (int k = 0; k < n; k++) step(1, SET_W'((ss << 3) | (k & 7)), 0, 0, 0);
  endtask

  task automatic t_reset;
    check("R7 reset vec_valid", vec_valid, 0);
    check("R7 reset vec_out", vec_out, 0);
    check("R8 acc_ready", acc_ready, 1);
  endtask

  task automatic t_basic;
    hits(0, 3); hits(5, 2); hits(7, 4); hits(3, 1);
    check_out("R3 no update before tick");
    step(0, 0, 1, 0, 0);
    check("R1 R2 basic vector", vec_out, 8'b1000_0001);
    check_out("R7 valid after first tick");
  endtask

  task automatic t_equal_and_index;
    hits(2, 2); hits(6, 3);
    for (int k = 0; k < 8; k++) step(1, SET_W'((4 << 3) | k), 0, 0, 0);
    step(0, 0, 1, 0, 0);
    check("R2 equal gives 0, R9 low bits ignored", vec_out, 8'b0101_0000);
    check_out("R1 model");
  endtask

  task automatic t_invalid;
    for (int k = 0; k < 10; k++) step(0, SET_W'(8 + k), 0, 0, 0);
    step(0, 0, 1, 0, 0);
    check("R8 invalid accesses not counted", vec_out, 8'h00);
  endtask

  task automatic t_hold;
    hits(1, 5);
    step(0, 0, 1, 0, 0);
    check("R2 ss1", vec_out, 8'h02);
    hits(6, 9);
    check("R3 vector held between ticks", vec_out, 8'h02);
    step(0, 0, 1, 0, 0);
    check("R3 update at tick", vec_out, 8'h40);
  endtask

  task automatic t_thr_write;
    step(0, 0, 0, 1, 0);
    hits(3, 1);
    step(0, 0, 1, 0, 0);
    check("R6 old threshold used at boundary", vec_out, 8'h00);
    hits(3, 1);
    step(0, 0, 1, 1, 5);
    check("R6 new threshold active next interval", vec_out, 8'h08);
    hits(3, 3);
    step(0, 0, 1, 0, 0);
    check("R6 write in tick cycle deferred", vec_out, 8'h08);
    hits(3, 5);
    step(0, 0, 1, 0, 0);
    check("R6 threshold 5 now active", vec_out, 8'h00);
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0);
  endtask

  task automatic t_overlap;
    hits(2, 1);
    step(1, SET_W'(5 << 3), 1, 0, 0);
    check("R4 tick-cycle access excluded", vec_out, 8'h04);
    step(0, 0, 1, 0, 0);
    check("R4 tick-cycle access counted next", vec_out, 8'h20);
    check_out("R4 model");
  endtask

  task automatic t_saturate;
    step(0, 0, 0, 1, CMAX - 1);
    step(0, 0, 1, 0, 0);
    hits(7, 300);
    step(0, 0, 1, 0, 0);
    check("R5 counter saturates not wraps", vec_out, 8'h80);
    check_out("R5 model");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_equal_and_index;
    t_invalid;
    t_hold;
    t_thr_write;
    t_overlap;
    t_saturate;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule